// File: doc/BRIEF.md
# Paged Indirect Register Bridge

This block lets a narrow management register file, with 16-bit registers and a 5-bit register address, reach a 32-bit internal address space. A page register at the top of the register map chooses what the window at addresses 0x10 to 0x18 shows. On the bridge page, that window holds a mode register, a write-address pair, a write-data pair, a read-address pair and a read-data pair. On every other page, the window is ordinary storage.

A 32-bit word is always given as two 16-bit halves, high half first. Writing the low half of the write data sends one write on the internal request/acknowledge bus. Writing the low half of the read address starts one internal read. The read result comes back split across the two read-data registers. With the increment mode bit set, the write address moves forward by one word after each write it sends. A bulk load therefore programs the start address once and then streams pairs of data halves.

Top module: `paged_reg_bridge`

## Requirements
- R1: After reset, every management register reads as 0, including the page register, the plain storage and all bridge registers. `bus_req` and `bridge_busy` are low.
- R2: Register 0x1F is the page register on every page. It reads back the last value written to it.
- R3: Addresses 0x00 to 0x1E are plain read/write storage, except addresses 0x10 to 0x18 while the page register holds 4. Accesses to that bridge window never change the plain storage.
- R4: With page 4 selected, the bridge map is: 0x10 mode, 0x11/0x12 write address high/low, 0x13/0x14 write data high/low, 0x15/0x16 read address high/low, 0x17/0x18 read data high/low. 0x10 to 0x16 read back what was written to them. Writes to 0x17 and 0x18 are ignored.
- R5: A write to 0x14 starts an internal write with `bus_we`=1. The address is {0x11, 0x12} and the data is {0x13, the value written to 0x14}. `bus_req`, `bus_addr`, `bus_wdata` and `bus_we` stay constant until `bus_ack`.
- R6: When mode bit 15 is 1, each accepted write advances the write-address pair by 4, with the carry going into the high half. When mode bit 15 is 0, the write-address pair is left unchanged.
- R7: A write to 0x16 starts an internal read with `bus_we`=0 at {0x15, the value written to 0x16}. On `bus_ack`, `bus_rdata[31:16]` appears in 0x17 and `bus_rdata[15:0]` appears in 0x18.
- R8: `bridge_busy` is high from the cycle after a transfer is accepted until the cycle after its acknowledge. Writes to 0x14 or 0x16 while a request is outstanding and unacknowledged start nothing, but their register values are still stored.
- R9: Each acknowledge completes exactly one transfer. `bus_req` falls in the cycle after `bus_ack`, unless a new transfer is accepted in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_addr | input | 5 | Management register address |
| mgmt_we | input | 1 | Management write strobe |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_rdata | output | 16 | Read data for the register at `mgmt_addr` (combinational) |
| bus_req | output | 1 | Internal transfer request |
| bus_we | output | 1 | Internal transfer is a write |
| bus_addr | output | 32 | Internal address |
| bus_wdata | output | 32 | Internal write data |
| bus_rdata | input | 32 | Internal read data, valid with `bus_ack` |
| bus_ack | input | 1 | Internal acknowledge |
| bridge_busy | output | 1 | A transfer is outstanding |

## Verification
The bench uses the default parameters: a 5-bit management address, 16-bit registers, a 32-bit internal bus, bridge page 4 and a step of 4. With these values the whole 31-entry plain storage can be swept, and every bridge slot can be reached. A burst that starts at 0x0000FFF8 makes the increment carry into the high address half. Addresses 0x00100000 and 0x00800000 exercise high-half decoding. The responder's acknowledge latency is varied between 0, 3 and 20 cycles. The 0-cycle case covers back-to-back burst commits. The 20-cycle case keeps a request open long enough to test that commits and read launches issued while busy are ignored.

// File: rtl/pgbr_pkg.sv
package pgbr_pkg;

    // Bridge window slots, ordered by their offset from the window base
    typedef enum logic [3:0] {
        SLOT_MODE  = 4'd0,
        SLOT_WA_HI = 4'd1,
        SLOT_WA_LO = 4'd2,
        SLOT_WD_HI = 4'd3,
        SLOT_WD_LO = 4'd4,
        SLOT_RA_HI = 4'd5,
        SLOT_RA_LO = 4'd6,
        SLOT_RD_HI = 4'd7,
        SLOT_RD_LO = 4'd8
    } slot_e;

    localparam int NUM_SLOTS = 9;

endpackage

// File: rtl/pgbr_decode.sv
module pgbr_decode #(
    parameter int MAW         = 5,
    parameter int DW          = 16,
    parameter int BRIDGE_PAGE = 4,
    parameter int PAGE_ADDR   = 31,
    parameter int WIN_LO      = 16
) (
    input  logic [MAW-1:0]       addr,
    input  logic [DW-1:0]        page,
    output logic                 page_sel,
    output logic                 win_sel,
    output pgbr_pkg::slot_e      slot
);
    localparam int WIN_HI = WIN_LO + pgbr_pkg::NUM_SLOTS - 1;

    logic [MAW-1:0] offset;

    always_comb begin
        offset   = addr - MAW'(WIN_LO);
        page_sel = (addr == MAW'(PAGE_ADDR));
        win_sel  = (page == DW'(BRIDGE_PAGE)) &&
                   (addr >= MAW'(WIN_LO)) && (addr <= MAW'(WIN_HI));
        slot     = pgbr_pkg::slot_e'(offset[3:0]);
    end
endmodule

// File: rtl/pgbr_plainfile.sv
module pgbr_plainfile #(
    parameter int MAW = 5,
    parameter int DW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [MAW-1:0] addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata
);
    localparam int NREG = (1 << MAW) - 1;

    logic [NREG-1:0][DW-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we && (32'(addr) < NREG)) mem_d[addr] = wdata;
        rdata = (32'(addr) < NREG) ? mem_q[addr] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    AST_PLAIN_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mem_q)); // R3
endmodule

// File: rtl/pgbr_core.sv
module pgbr_core #(
    parameter int DW        = 16,
    parameter int BAW       = 32,
    parameter int BDW       = 32,
    parameter int ADDR_STEP = 4,
    parameter int INC_BIT   = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  pgbr_pkg::slot_e reg_slot,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            bus_req,
    output logic            bus_we,
    output logic [BAW-1:0]  bus_addr,
    output logic [BDW-1:0]  bus_wdata,
    input  logic [BDW-1:0]  bus_rdata,
    input  logic            bus_ack,
    output logic            busy
);
    import pgbr_pkg::*;

    typedef struct packed {
        logic [DW-1:0]  mode;
        logic [BAW-1:0] wa;
        logic [BDW-1:0] wd;
        logic [BAW-1:0] ra;
        logic [BDW-1:0] rd;
        logic           req;
        logic           we;
        logic [BAW-1:0] addr;
        logic [BDW-1:0] wdata;
    } st_t;

    st_t st_d, st_q;
    logic free;

    always_comb begin
        st_d = st_q;
        free = !st_q.req || bus_ack;
        if (st_q.req && bus_ack) begin
            st_d.req = 1'b0;
            if (!st_q.we) st_d.rd = bus_rdata;
        end
        if (reg_we) begin
            unique case (reg_slot)
                SLOT_MODE:  st_d.mode           = reg_wdata;
                SLOT_WA_HI: st_d.wa[BAW-1:DW]   = reg_wdata;
                SLOT_WA_LO: st_d.wa[DW-1:0]     = reg_wdata;
                SLOT_WD_HI: st_d.wd[BDW-1:DW]   = reg_wdata;
                SLOT_WD_LO: begin
                    st_d.wd[DW-1:0] = reg_wdata;
                    if (free) begin
                        st_d.req   = 1'b1;
                        st_d.we    = 1'b1;
                        st_d.addr  = st_q.wa;
                        st_d.wdata = {st_q.wd[BDW-1:DW], reg_wdata};
                        if (st_q.mode[INC_BIT]) st_d.wa = st_q.wa + BAW'(ADDR_STEP);
                    end
                end
                SLOT_RA_HI: st_d.ra[BAW-1:DW]   = reg_wdata;
                SLOT_RA_LO: begin
                    st_d.ra[DW-1:0] = reg_wdata;
                    if (free) begin
                        st_d.req  = 1'b1;
                        st_d.we   = 1'b0;
                        st_d.addr = {st_q.ra[BAW-1:DW], reg_wdata};
                    end
                end
                default: ;
            endcase
        end
        unique case (reg_slot)
            SLOT_MODE:  reg_rdata = st_q.mode;
            SLOT_WA_HI: reg_rdata = st_q.wa[BAW-1:DW];
            SLOT_WA_LO: reg_rdata = st_q.wa[DW-1:0];
            SLOT_WD_HI: reg_rdata = st_q.wd[BDW-1:DW];
            SLOT_WD_LO: reg_rdata = st_q.wd[DW-1:0];
            SLOT_RA_HI: reg_rdata = st_q.ra[BAW-1:DW];
            SLOT_RA_LO: reg_rdata = st_q.ra[DW-1:0];
            SLOT_RD_HI: reg_rdata = st_q.rd[BDW-1:DW];
            SLOT_RD_LO: reg_rdata = st_q.rd[DW-1:0];
            default:    reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_req   = st_q.req;
    assign bus_we    = st_q.we;
    assign bus_addr  = st_q.addr;
    assign bus_wdata = st_q.wdata;
    assign busy      = st_q.req;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req); // R5
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we)); // R5
    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack && !(reg_we && (reg_slot == SLOT_WD_LO || reg_slot == SLOT_RA_LO))
        |=> !bus_req); // R9
    AST_FIXED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_slot == SLOT_WD_LO && !st_q.mode[INC_BIT] |=> $stable(st_q.wa)); // R6
    AST_INC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_slot == SLOT_WD_LO && st_q.mode[INC_BIT] && !bus_req
        |=> st_q.wa == $past(st_q.wa) + BAW'(ADDR_STEP)); // R6
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !bus_ack |=> busy); // R8
endmodule

// File: rtl/paged_reg_bridge.sv
module paged_reg_bridge #(
    parameter int MAW         = 5,
    parameter int DW          = 16,
    parameter int BAW         = 32,
    parameter int BDW         = 32,
    parameter int BRIDGE_PAGE = 4,
    parameter int PAGE_ADDR   = 31,
    parameter int WIN_LO      = 16,
    parameter int ADDR_STEP   = 4,
    parameter int INC_BIT     = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [MAW-1:0]  mgmt_addr,
    input  logic            mgmt_we,
    input  logic [DW-1:0]   mgmt_wdata,
    output logic [DW-1:0]   mgmt_rdata,
    output logic            bus_req,
    output logic            bus_we,
    output logic [BAW-1:0]  bus_addr,
    output logic [BDW-1:0]  bus_wdata,
    input  logic [BDW-1:0]  bus_rdata,
    input  logic            bus_ack,
    output logic            bridge_busy
);
    typedef struct packed {
        logic [DW-1:0] page;
    } top_st_t;

    top_st_t         top_d, top_q;
    logic            page_sel, win_sel;
    pgbr_pkg::slot_e slot;
    logic [DW-1:0]   plain_rdata, core_rdata;

    pgbr_decode #(.MAW(MAW), .DW(DW), .BRIDGE_PAGE(BRIDGE_PAGE),
                  .PAGE_ADDR(PAGE_ADDR), .WIN_LO(WIN_LO)) i_decode (
        .addr(mgmt_addr), .page(top_q.page),
        .page_sel(page_sel), .win_sel(win_sel), .slot(slot)
    );

    pgbr_plainfile #(.MAW(MAW), .DW(DW)) i_plain (
        .clk(clk), .rst_n(rst_n),
        .we(mgmt_we && !page_sel && !win_sel),
        .addr(mgmt_addr), .wdata(mgmt_wdata), .rdata(plain_rdata)
    );

    pgbr_core #(.DW(DW), .BAW(BAW), .BDW(BDW),
                .ADDR_STEP(ADDR_STEP), .INC_BIT(INC_BIT)) i_core (
        .clk(clk), .rst_n(rst_n),
        .reg_we(mgmt_we && win_sel), .reg_slot(slot),
        .reg_wdata(mgmt_wdata), .reg_rdata(core_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .busy(bridge_busy)
    );

    always_comb begin
        top_d = top_q;
        if (mgmt_we && page_sel) top_d.page = mgmt_wdata;
        if (page_sel)     mgmt_rdata = top_q.page;
        else if (win_sel) mgmt_rdata = core_rdata;
        else              mgmt_rdata = plain_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mgmt_we && page_sel) |=> $stable(top_q.page)); // R2
endmodule

// File: tb/test_paged_reg_bridge.sv
`timescale 1ns/1ps
module test_paged_reg_bridge;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [4:0]  m_addr = 0;
    logic        m_we = 0;
    logic [15:0] m_wdata = 0;
    logic [15:0] m_rdata;
    logic        bus_req, bus_we, bus_ack = 0, busy;
    logic [31:0] bus_addr, bus_wdata, bus_rdata = 0;

    int tests = 0, fails = 0;
    bit done = 0;
    int lat = 0, lat_cnt = 0;
    logic [31:0] log_addr [32];
    logic [31:0] log_data [32];
    int log_n = 0, rd_n = 0;
    logic [15:0] exp_plain [32];

    always #2 clk = ~clk;

    paged_reg_bridge i_paged_reg_bridge (
        .clk(clk), .rst_n(rst_n), .mgmt_addr(m_addr), .mgmt_we(m_we),
        .mgmt_wdata(m_wdata), .mgmt_rdata(m_rdata), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bridge_busy(busy)
    );

    function automatic logic [31:0] rfun(input logic [31:0] a);
        return {~a[15:0], a[31:16]} ^ 32'h5A5A_0F0F;
    endfunction

    // Internal bus responder with programmable latency
    always @(posedge clk) begin
        if (bus_req && !bus_ack) begin
            if (lat_cnt >= lat) begin
                bus_ack <= 1'b1;
                lat_cnt <= 0;
                if (bus_we) begin
                    if (log_n < 32) begin
                        log_addr[log_n] <= bus_addr;
                        log_data[log_n] <= bus_wdata;
                    end
                    log_n <= log_n + 1;
                end else begin
                    bus_rdata <= rfun(bus_addr);
                    rd_n <= rd_n + 1;
                end
            end else lat_cnt <= lat_cnt + 1;
        end else bus_ack <= 1'b0;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        m_addr = a; m_wdata = d; m_we = 1;
        @(negedge clk);
        m_we = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        m_addr = a;
        #1;
        d = m_rdata;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, v2;
        int base_n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", {31'd0, busy}, 0);
        chk("R1 bus_req", {31'd0, bus_req}, 0);
        for (int a = 0; a < 32; a++) begin
            rd(5'(a), v);
            chk("R1 reset value", {16'd0, v}, 0);
        end
        // R3: sweep plain storage on page 0
        for (int a = 0; a < 31; a++) begin
            exp_plain[a] = 16'(16'h1000 + a * 37);
            wr(5'(a), exp_plain[a]);
        end
        for (int a = 0; a < 31; a++) begin
            rd(5'(a), v);
            chk("R3 plain readback", {16'd0, v}, {16'd0, exp_plain[a]});
        end
        // R2: page register
        wr(5'h1F, 16'h0007);
        rd(5'h1F, v);
        chk("R2 page readback", {16'd0, v}, 32'h7);
        rd(5'h12, v);
        chk("R3 page 7 window is plain", {16'd0, v}, {16'd0, exp_plain[18]});
        wr(5'h1F, 16'h0004);
        rd(5'h1F, v);
        chk("R2 page readback 4", {16'd0, v}, 32'h4);
        // R4: bridge register readback
        wr(5'h10, 16'h8001); wr(5'h11, 16'h1234); wr(5'h12, 16'h5678);
        wr(5'h13, 16'h9ABC); wr(5'h15, 16'hDEF0);
        rd(5'h10, v); chk("R4 mode", {16'd0, v}, 32'h8001);
        rd(5'h11, v); chk("R4 wa_hi", {16'd0, v}, 32'h1234);
        rd(5'h12, v); chk("R4 wa_lo", {16'd0, v}, 32'h5678);
        rd(5'h13, v); chk("R4 wd_hi", {16'd0, v}, 32'h9ABC);
        rd(5'h15, v); chk("R4 ra_hi", {16'd0, v}, 32'hDEF0);
        wr(5'h17, 16'hFFFF); wr(5'h18, 16'hFFFF);
        rd(5'h17, v); chk("R4 rd_hi read-only", {16'd0, v}, 0);
        rd(5'h18, v); chk("R4 rd_lo read-only", {16'd0, v}, 0);
        // R3: outside window on page 4 is plain
        wr(5'h1A, 16'hA5A5); exp_plain[26] = 16'hA5A5;
        rd(5'h1A, v); chk("R3 page 4 outside window", {16'd0, v}, 32'hA5A5);
        rd(5'h05, v); chk("R3 page 4 low plain", {16'd0, v}, {16'd0, exp_plain[5]});
        // R5/R6: fixed-address writes
        wr(5'h10, 16'h0000);
        wr(5'h11, 16'h0080); wr(5'h12, 16'h0000);
        for (int i = 0; i < 3; i++) begin
            base_n = log_n;
            wr(5'h13, 16'(16'hDE00 + i));
            wr(5'h14, 16'(16'hBE00 + i));
            wait_idle();
            chk("R5 one write", log_n, base_n + 1);
            chk("R5 fixed addr", log_addr[base_n], 32'h0080_0000);
            chk("R5 data", log_data[base_n], {16'(16'hDE00 + i), 16'(16'hBE00 + i)});
        end
        rd(5'h11, v); rd(5'h12, v2);
        chk("R6 fixed addr unchanged", {v, v2}, 32'h0080_0000);
        chk("R9 idle after ack", {31'd0, bus_req}, 0);
        // R6: incrementing burst across the half boundary, back to back
        lat = 0;
        wr(5'h10, 16'h8000);
        wr(5'h11, 16'h0000); wr(5'h12, 16'hFFF8);
        base_n = log_n;
        for (int i = 0; i < 6; i++) begin
            wr(5'h13, 16'(i));
            wr(5'h14, 16'(i * 16'h111));
        end
        wait_idle();
        chk("R9 burst count", log_n, base_n + 6);
        for (int i = 0; i < 6; i++) begin
            chk("R6 burst addr", log_addr[base_n + i], 32'h0000_FFF8 + 32'(i * 4));
            chk("R6 burst data", log_data[base_n + i], {16'(i), 16'(i * 16'h111)});
        end
        rd(5'h11, v); rd(5'h12, v2);
        chk("R6 final addr carry", {v, v2}, 32'h0001_0010);
        // R7: reads at several addresses and latencies
        wr(5'h10, 16'h0000);
        for (int i = 0; i < 4; i++) begin
            logic [31:0] ra;
            ra = (i == 0) ? 32'h0010_0000 : (i == 1) ? 32'h0080_0000 :
                 (i == 2) ? 32'h000C_A0F8 : 32'hFFFF_0004;
            lat = (i % 2) * 3;
            wr(5'h15, ra[31:16]);
            wr(5'h16, ra[15:0]);
            wait_idle();
            rd(5'h17, v); rd(5'h18, v2);
            chk("R7 read data", {v, v2}, rfun(ra));
        end
        // R8: commits and launches while busy are ignored
        lat = 20;
        base_n = log_n;
        wr(5'h11, 16'h0000); wr(5'h12, 16'h0040);
        wr(5'h13, 16'h1111);
        wr(5'h14, 16'h2222);
        chk("R8 busy after commit", {31'd0, busy}, 1);
        begin
            int rn;
            rn = rd_n;
            wr(5'h14, 16'h3333);
            wr(5'h16, 16'h0100);
            chk("R8 still busy", {31'd0, busy}, 1);
            wait_idle();
            chk("R8 ignored write", log_n, base_n + 1);
            chk("R8 first write data", log_data[base_n], 32'h1111_2222);
            chk("R8 ignored read", rd_n, rn);
        end
        rd(5'h14, v); chk("R8 stored while busy", {16'd0, v}, 32'h3333);
        rd(5'h17, v); rd(5'h18, v2);
        chk("R8 read data kept", {v, v2}, rfun(32'hFFFF_0004));
        chk("R9 req low at idle", {31'd0, bus_req}, 0);
        // R3: plain storage untouched by bridge traffic
        wr(5'h1F, 16'h0000);
        for (int a = 16; a <= 24; a++) begin
            rd(5'(a), v);
            chk("R3 window plain kept", {16'd0, v}, {16'd0, exp_plain[a]});
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule